// File: doc/BRIEF.md
# Agree-Mode Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Instead of storing a direction, each 2-bit saturating counter stores whether the branch tends to match a bias bit that is kept per address in the branch target buffer. On a target-buffer hit, the predicted direction is the bias bit flipped when the counter leans towards disagreement. Two branches with opposite biases can then share a counter without harm, provided each one usually follows its own bias.

When the target buffer misses, no bias is available. The prediction is then forced to not-taken. A separate low-confidence flag is raised when the counter would have pointed away from a not-taken default. When a branch resolves, the counter is trained towards agree or towards disagree. When the branch had no target-buffer entry, the block returns the resolved direction as the bias the buffer should store in its newly allocated entry.

A prediction comes out two clock edges after its request. The counter is read on the first edge and the output register is loaded on the second. A training request changes the counter on the edge that samples it.

Top module: `agree_predictor`

## Requirements
- R1: While reset is high, and on the first edge after it falls, `pred_valid_o`, `pred_taken_o`, `pred_lowconf_o` and `alloc_valid_o` are 0. Reset sets every counter to 2'b10 (weakly agree).
- R2: On a hit (`pred_hit_i`=1), the outputs appear on the second rising edge after the request. `pred_taken_o` equals `pred_bias_i` XOR (counter bit 1 == 0).
- R3: On a miss (`pred_hit_i`=0), `pred_taken_o` is 0. `pred_lowconf_o` is 1 exactly when counter bit 1 is 0.
- R4: On a hit, `pred_lowconf_o` is 0.
- R5: A training request moves the counter up by one when the resolved direction equals the bias, and down by one otherwise. The counter saturates at 3 and at 0, and bit 1 is the agree indication.
- R6: The counter index is address bits [11:2]. Requests on different indices do not affect each other's counters.
- R7: When a read and a training request hit the same index in one cycle, the read returns the counter value from before the update.
- R8: A training request with `upd_hit_i`=0 uses the resolved direction as the bias, so it always trains towards agree. On the next edge it raises `alloc_valid_o`, with `alloc_bias_o` equal to `upd_taken_i`. Otherwise `alloc_valid_o` is 0.
- R9: With `pred_valid_i` low, `pred_valid_o` is low two edges later. With `upd_valid_i` low, no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid_i | input | 1 | Prediction request |
| pred_addr_i | input | 10 | Branch address bits [11:2] |
| pred_hit_i | input | 1 | Target buffer hit for this branch |
| pred_bias_i | input | 1 | Per-address bias from the target buffer (1 = taken) |
| upd_valid_i | input | 1 | Resolution / training request |
| upd_addr_i | input | 10 | Resolved branch address bits [11:2] |
| upd_hit_i | input | 1 | Branch had a target buffer entry |
| upd_bias_i | input | 1 | Bias stored in that entry |
| upd_taken_i | input | 1 | Resolved direction (1 = taken) |
| pred_valid_o | output | 1 | Prediction valid |
| pred_taken_o | output | 1 | Predicted direction |
| pred_lowconf_o | output | 1 | Miss with counter leaning to disagree |
| alloc_valid_o | output | 1 | New entry bias is available |
| alloc_bias_o | output | 1 | Bias to store in the new entry |

## Verification
The bench drives each prediction request and checks the matching outputs two negative edges later. To do this, it keeps the expected values in a two-deep queue that it advances once per cycle. The allocation outputs are checked one negative edge after their training request, from a one-deep holding slot. The expected value of each prediction is computed from the bench's own counter model before that cycle's training is applied. This matches the rule that a same-cycle read sees the old value, and the training reaches the model's counter in the cycle it was driven.

// File: rtl/agree_pred_pkg.sv
package agree_pred_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_AGREE = 2'b10;
  localparam ctr_t CTR_MAX        = 2'b11;
  localparam ctr_t CTR_MIN        = 2'b00;

  // Saturating step towards agree (up) or disagree (down).
  function automatic ctr_t ctr_train(input ctr_t cur, input logic agree);
    ctr_t nxt;
    if (agree) nxt = (cur == CTR_MAX) ? cur : ctr_t'(cur + 2'd1);
    else       nxt = (cur == CTR_MIN) ? cur : ctr_t'(cur - 2'd1);
    return nxt;
  endfunction

endpackage

// File: rtl/agree_ctr_table.sv
module agree_ctr_table
  import agree_pred_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_agree_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_agree_i
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];
  logic rd_agree_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WEAK_AGREE;
      rd_agree_q <= 1'b0;
    end else begin
      rd_agree_q <= tbl[rd_idx_i][1];
      if (wr_en_i) tbl[wr_idx_i] <= ctr_train(tbl[wr_idx_i], wr_agree_i);
    end
  end

  assign rd_agree_o = rd_agree_q;

endmodule

// File: rtl/agree_out_stage.sv
module agree_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic valid_i,
  input  logic hit_i,
  input  logic bias_i,
  input  logic agree_i,
  output logic valid_o,
  output logic taken_o,
  output logic lowconf_o
);

  logic disagree;
  logic taken_d;
  logic lowconf_d;

  always_comb begin
    disagree  = ~agree_i;
    taken_d   = hit_i & (bias_i ^ disagree);
    lowconf_d = ~hit_i & disagree;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      lowconf_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      taken_o   <= valid_i & taken_d;
      lowconf_o <= valid_i & lowconf_d;
    end
  end

endmodule

// File: rtl/agree_alloc_stage.sv
module agree_alloc_stage (
  input  logic clk,
  input  logic rst,
  input  logic new_i,
  input  logic taken_i,
  output logic valid_o,
  output logic bias_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      bias_o  <= 1'b0;
    end else begin
      valid_o <= new_i;
      bias_o  <= new_i & taken_i;
    end
  end

endmodule

// File: rtl/agree_predictor.sv
module agree_predictor
  import agree_pred_pkg::*;
#(
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pred_valid_i,
  input  logic [IDX_LSB+IDX_W-1:IDX_LSB] pred_addr_i,
  input  logic                         pred_hit_i,
  input  logic                         pred_bias_i,
  input  logic                         upd_valid_i,
  input  logic [IDX_LSB+IDX_W-1:IDX_LSB] upd_addr_i,
  input  logic                         upd_hit_i,
  input  logic                         upd_bias_i,
  input  logic                         upd_taken_i,
  output logic                         pred_valid_o,
  output logic                         pred_taken_o,
  output logic                         pred_lowconf_o,
  output logic                         alloc_valid_o,
  output logic                         alloc_bias_o
);

  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             eff_bias;
  logic             upd_agree;
  logic             rd_agree;
  logic             s1_valid, s1_hit, s1_bias;

  assign rd_idx = pred_addr_i;
  assign wr_idx = upd_addr_i;

  // A missing entry takes the resolved direction as its bias.
  always_comb begin
    eff_bias  = upd_hit_i ? upd_bias_i : upd_taken_i;
    upd_agree = (upd_taken_i == eff_bias);
  end

  agree_ctr_table #(.IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .rd_idx_i   (rd_idx),
    .rd_agree_o (rd_agree),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (wr_idx),
    .wr_agree_i (upd_agree)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_bias  <= 1'b0;
    end else begin
      s1_valid <= pred_valid_i;
      s1_hit   <= pred_hit_i;
      s1_bias  <= pred_bias_i;
    end
  end

  agree_out_stage u_out (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (s1_valid),
    .hit_i     (s1_hit),
    .bias_i    (s1_bias),
    .agree_i   (rd_agree),
    .valid_o   (pred_valid_o),
    .taken_o   (pred_taken_o),
    .lowconf_o (pred_lowconf_o)
  );

  agree_alloc_stage u_alloc (
    .clk     (clk),
    .rst     (rst),
    .new_i   (upd_valid_i & ~upd_hit_i),
    .taken_i (upd_taken_i),
    .valid_o (alloc_valid_o),
    .bias_o  (alloc_bias_o)
  );

endmodule

// File: rtl/agree_predictor_chk.sv
module agree_predictor_chk (
  input logic clk,
  input logic rst,
  input logic pred_valid_i,
  input logic pred_hit_i,
  input logic upd_valid_i,
  input logic upd_hit_i,
  input logic upd_taken_i,
  input logic pred_valid_o,
  input logic pred_taken_o,
  input logic pred_lowconf_o,
  input logic alloc_valid_o,
  input logic alloc_bias_o
);

  logic [1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    (seen == 2'd0) |-> (!pred_valid_o && !pred_taken_o && !pred_lowconf_o && !alloc_valid_o));

  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst || seen < 2'd2)
    pred_valid_o == $past(pred_valid_i, 2));

  a_r3_miss_not_taken: assert property (@(posedge clk) disable iff (rst || seen < 2'd2)
    (pred_valid_o && !$past(pred_hit_i, 2)) |-> !pred_taken_o);

  a_r4_hit_confident: assert property (@(posedge clk) disable iff (rst || seen < 2'd2)
    (pred_valid_o && $past(pred_hit_i, 2)) |-> !pred_lowconf_o);

  a_r8_alloc_bias: assert property (@(posedge clk) disable iff (rst || seen < 2'd1)
    $past(upd_valid_i && !upd_hit_i) |-> (alloc_valid_o && alloc_bias_o == $past(upd_taken_i)));

  a_r8_alloc_quiet: assert property (@(posedge clk) disable iff (rst || seen < 2'd1)
    !$past(upd_valid_i && !upd_hit_i) |-> !alloc_valid_o);

endmodule

bind agree_predictor agree_predictor_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .pred_valid_i   (pred_valid_i),
  .pred_hit_i     (pred_hit_i),
  .upd_valid_i    (upd_valid_i),
  .upd_hit_i      (upd_hit_i),
  .upd_taken_i    (upd_taken_i),
  .pred_valid_o   (pred_valid_o),
  .pred_taken_o   (pred_taken_o),
  .pred_lowconf_o (pred_lowconf_o),
  .alloc_valid_o  (alloc_valid_o),
  .alloc_bias_o   (alloc_bias_o)
);

// File: tb/test_agree_predictor.sv
`timescale 1ns/1ps
module test_agree_predictor;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pv = 0, ph = 0, pb = 0, uv = 0, uh = 0, ub = 0, ut = 0;
  logic [11:2] pa = '0, ua = '0;
  logic pred_valid_o, pred_taken_o, pred_lowconf_o, alloc_valid_o, alloc_bias_o;

  int n_vec = 0;
  int n_bad = 0;
  int mdl [1024];
  bit done = 0;

  // expectation pipeline: d1 = one cycle old, d2 = two cycles old
  logic d1_v = 0, d1_t = 0, d1_l = 0, d2_v = 0, d2_t = 0, d2_l = 0;
  logic d1_h = 0, d2_h = 0;
  string d1_tag = "R1", d2_tag = "R1";
  logic a1_v = 0, a1_b = 0;

  always #5 clk = ~clk;

  agree_predictor i_agree_predictor (
    .clk(clk), .rst(rst),
    .pred_valid_i(pv), .pred_addr_i(pa), .pred_hit_i(ph), .pred_bias_i(pb),
    .upd_valid_i(uv), .upd_addr_i(ua), .upd_hit_i(uh), .upd_bias_i(ub), .upd_taken_i(ut),
    .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o), .pred_lowconf_o(pred_lowconf_o),
    .alloc_valid_o(alloc_valid_o), .alloc_bias_o(alloc_bias_o)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic int train(input int c, input bit agree);
    if (agree) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  // One cycle: check outputs due now, drive new inputs, advance model.
  task automatic step(input string tag, input logic p_v, input logic [11:2] p_a,
                      input logic p_h, input logic p_b, input logic u_v,
                      input logic [11:2] u_a, input logic u_h, input logic u_b,
                      input logic u_t);
    int  c;
    logic e_t, e_l, eb;
    check(d2_tag, "pred_valid_o", pred_valid_o, d2_v);
    if (d2_v) begin
      check(d2_tag, "pred_taken_o", pred_taken_o, d2_t);
      check(d2_h ? "R4" : "R3", "pred_lowconf_o", pred_lowconf_o, d2_l);
    end
    check("R8", "alloc_valid_o", alloc_valid_o, a1_v);
    if (a1_v) check("R8", "alloc_bias_o", alloc_bias_o, a1_b);
    pv = p_v; pa = p_a; ph = p_h; pb = p_b;
    uv = u_v; ua = u_a; uh = u_h; ub = u_b; ut = u_t;
    c   = mdl[p_a];
    e_t = p_h ? (p_b ^ ~c[1]) : 1'b0;
    e_l = p_h ? 1'b0 : ~c[1];
    d2_v = d1_v; d2_t = d1_t; d2_l = d1_l; d2_h = d1_h; d2_tag = d1_tag;
    d1_v = p_v; d1_t = e_t; d1_l = e_l; d1_h = p_h;
    d1_tag = (tag != "") ? tag : (p_h ? "R2" : "R3");
    a1_v = u_v & ~u_h; a1_b = u_t;
    // R7: training lands after the read above used the old value
    if (u_v) begin
      eb = u_h ? u_b : u_t;
      mdl[u_a] = train(mdl[u_a], u_t == eb);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("R9", 0, '0, 0, 0, 0, '0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mdl[i] = 2;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "pred_valid_o in reset", pred_valid_o, 0);
    check("R1", "alloc_valid_o in reset", alloc_valid_o, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", "pred_valid_o after reset", pred_valid_o, 0);
    check("R1", "pred_taken_o after reset", pred_taken_o, 0);

    // R1: weakly agree after reset, with both bias values
    step("R1", 1, 10'd5, 1, 1, 0, '0, 0, 0, 0);
    step("R1", 1, 10'd6, 1, 0, 0, '0, 0, 0, 0);
    step("R1", 1, 10'd7, 0, 0, 0, '0, 0, 0, 0);
    idle(2);
    // R5: saturate upward at index 9, bias 1
    for (int i = 0; i < 4; i++) step("R5", 0, '0, 0, 0, 1, 10'd9, 1, 1, 1);
    step("R5", 1, 10'd9, 1, 1, 1, 10'd9, 1, 1, 0);   // R7 same-index read sees 3
    step("R5", 1, 10'd9, 1, 1, 1, 10'd9, 1, 1, 0);   // reads 2 -> taken
    step("R5", 1, 10'd9, 1, 1, 0, '0, 0, 0, 0);      // reads 1 -> not taken
    step("R6", 1, 10'd8, 1, 1, 0, '0, 0, 0, 0);      // neighbour untouched
    // R5: saturate downward at index 9
    for (int i = 0; i < 3; i++) step("R5", 0, '0, 0, 0, 1, 10'd9, 1, 0, 1);
    step("R3", 1, 10'd9, 0, 0, 0, '0, 0, 0, 0);      // miss: lowconf raised
    step("R5", 1, 10'd9, 1, 0, 0, '0, 0, 0, 0);      // bias 0 disagree -> taken
    // R8: miss update trains towards agree and reports the new bias
    step("R8", 0, '0, 0, 0, 1, 10'd9, 0, 0, 1);
    step("R8", 1, 10'd9, 1, 1, 1, 10'd9, 0, 1, 0);
    step("R8", 1, 10'd9, 1, 1, 0, '0, 0, 0, 0);
    // R9: update with valid low has no effect
    step("R9", 0, '0, 0, 0, 0, 10'd9, 1, 1, 0);
    step("R9", 1, 10'd9, 1, 1, 0, '0, 0, 0, 0);
    idle(2);

    // Constrained random on a small index set to force sharing and saturation
    for (int k = 0; k < 4000; k++) begin
      logic [11:2] a0, a1;
      a0 = 10'(($urandom % 6) * 97);
      a1 = 10'(($urandom % 6) * 97);
      step("", 1'($urandom % 4 != 0), a0, 1'($urandom % 3 != 0), 1'($urandom),
           1'($urandom % 3 != 0), a1, 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom));
    end
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule